// File: doc/BRIEF.md
# Masked Scalar Half-Precision Move Unit

This execution unit performs a bit-exact move of one 16-bit floating-point element in three forms. It can load a value from memory into a vector register, store the low element of a vector register to memory, or merge two registers: the low element comes from one source and bits 127:16 come from a second source. The unit receives already-decoded instruction fields: the opcode byte, a flag that says whether the operand is a register or memory, the two operand register indices, an extra source index, a mask register index and a zeroing bit. It owns a 32-entry, 512-bit vector register file and an 8-entry, 8-bit mask register file.

Bit 0 of the selected mask register decides whether the low element is written. When that bit is clear, the low element either becomes zero or keeps the old destination value, depending on the zeroing bit. Mask index 0 means that no mask is in use. Each accepted operation is registered: one cycle later the unit raises a done pulse together with a register write, a memory write or an illegal flag. The committed register value is visible to the operation issued in the next cycle.

The surrounding pipeline uses two setup ports to initialise register contents: one for the vector file and one for the mask file. A move that commits in the same cycle takes priority over the vector setup port.

Top module: `hmov_unit`

## Requirements
- R1: Opcode 0x10 with is_mem_i=1 is a load. It writes register reg_idx_i. The low 16 bits come from mem_rdata_i when the element is enabled, and bits 511:16 of the result are zero.
- R2: Opcode 0x11 with is_mem_i=1 is a store. When the element is enabled, mem_we_o pulses and mem_wdata_o carries bits 15:0 of register reg_idx_i. No register write occurs.
- R3: With is_mem_i=0, both opcodes are the register form and give identical data. Opcode 0x10 writes reg_idx_i and takes its low element from rm_idx_i. Opcode 0x11 writes rm_idx_i and takes its low element from reg_idx_i. Bits 127:16 come from register src1_idx_i, and bits 511:128 are zero.
- R4: The element is enabled when mask_idx_i is 0, whatever mask register 0 holds. It is also enabled when bit 0 of the selected mask register is 1.
- R5: For a load or a register-form move with the element disabled and zero_i=1, result bits 15:0 are zero.
- R6: For a load or a register-form move with the element disabled and zero_i=0, result bits 15:0 equal the old bits 15:0 of the destination register.
- R7: A store with the element disabled makes no memory write and no register write, and still reports done.
- R8: A store with zero_i=1 raises illegal_o and makes no memory write and no register write.
- R9: An opcode other than 0x10 or 0x11 raises illegal_o and makes no writes.
- R10: done_o is high for exactly the cycle after each cycle with valid_i=1. Each done cycle carries at most one of rd_we_o, mem_we_o and illegal_o, and none of them is high without done_o.
- R11: The 16-bit pattern is moved unchanged, including NaN, infinity and denormal encodings.
- R12: A register write committed by one operation is seen by an operation issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| opcode_i | input | 8 | Opcode byte (0x10 or 0x11) |
| is_mem_i | input | 1 | 1: memory operand, 0: register operand |
| reg_idx_i | input | 5 | Register index from the reg field |
| rm_idx_i | input | 5 | Register index from the r/m field |
| src1_idx_i | input | 5 | Extra source register index, upper bits in the register form |
| mask_idx_i | input | 3 | Mask register index, 0 = unmasked |
| zero_i | input | 1 | Zeroing selected |
| mem_rdata_i | input | 16 | Loaded memory element |
| fill_we_i | input | 1 | Vector register setup write |
| fill_idx_i | input | 5 | Vector register setup index |
| fill_data_i | input | 512 | Vector register setup data |
| mfill_we_i | input | 1 | Mask register setup write |
| mfill_idx_i | input | 3 | Mask register setup index |
| mfill_data_i | input | 8 | Mask register setup data |
| done_o | output | 1 | Operation completed |
| illegal_o | output | 1 | Operation rejected |
| rd_we_o | output | 1 | Destination register written |
| rd_idx_o | output | 5 | Destination register index |
| rd_data_o | output | 512 | Value written to the destination register |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 16 | Memory write data |

## Verification
The hardest case to reach is a disabled element that keeps its old destination value. Reaching it requires three things in the same operation: a destination already holding a known, non-trivial low element, a nonzero mask index, and a mask register whose bit 0 is clear while its other bits are set. The bench first loads distinct patterns into both files through the setup ports, then issues loads and register-form moves against them. It also issues a move right after a committed write, and a move that names mask register 0 while that register holds a pattern that would block the write.

// File: rtl/hmov_pkg.sv
package hmov_pkg;
  localparam logic [7:0] OPC_TO_REG   = 8'h10;
  localparam logic [7:0] OPC_FROM_REG = 8'h11;

  typedef enum logic [1:0] {
    FORM_LOAD  = 2'd0,
    FORM_STORE = 2'd1,
    FORM_MERGE = 2'd2,
    FORM_BAD   = 2'd3
  } form_e;

  typedef struct packed {
    form_e form;
    logic  use_mask;
    logic  zero;
  } ctl_t;
endpackage

// File: rtl/hmov_regfile.sv
module hmov_regfile #(
  parameter int unsigned WIDTH = 512,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned NRD   = 3,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              widx_i,
  input  logic [WIDTH-1:0]           wdata_i,
  input  logic [NRD-1:0][AW-1:0]     ridx_i,
  output logic [NRD-1:0][WIDTH-1:0]  rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
    assign rdata_o[p] = mem_q[ridx_i[p]];
  end
endmodule

// File: rtl/hmov_decode.sv
module hmov_decode
  import hmov_pkg::*;
#(
  parameter int unsigned RAW = 5,
  parameter int unsigned MAW = 3
) (
  input  logic [7:0]     opcode_i,
  input  logic           is_mem_i,
  input  logic [RAW-1:0] reg_idx_i,
  input  logic [RAW-1:0] rm_idx_i,
  input  logic [MAW-1:0] mask_idx_i,
  input  logic           zero_i,
  output ctl_t           ctl_o,
  output logic [RAW-1:0] dst_idx_o,
  output logic [RAW-1:0] src_idx_o
);
  logic op_to, op_from;
  assign op_to   = (opcode_i == OPC_TO_REG);
  assign op_from = (opcode_i == OPC_FROM_REG);

  always_comb begin
    ctl_o.use_mask = (mask_idx_i != '0);
    ctl_o.zero     = zero_i;
    if (op_to)
      ctl_o.form = is_mem_i ? FORM_LOAD : FORM_MERGE;
    else if (op_from)
      ctl_o.form = is_mem_i ? (zero_i ? FORM_BAD : FORM_STORE) : FORM_MERGE;
    else
      ctl_o.form = FORM_BAD;
  end

  // register form 0x11 swaps operand roles
  assign dst_idx_o = (op_from && !is_mem_i) ? rm_idx_i : reg_idx_i;
  assign src_idx_o = (op_to && !is_mem_i) ? rm_idx_i : reg_idx_i;
endmodule

// File: rtl/hmov_merge.sv
module hmov_merge
  import hmov_pkg::*;
#(
  parameter int unsigned VLEN = 512,
  parameter int unsigned LANE = 128,
  parameter int unsigned ELEM = 16,
  localparam int unsigned NEL = VLEN / ELEM,
  localparam int unsigned LEL = LANE / ELEM
) (
  input  ctl_t                 ctl_i,
  input  logic                 mask_bit_i,
  input  logic [ELEM-1:0]      src_low_i,
  input  logic [ELEM-1:0]      old_low_i,
  input  logic [LANE-ELEM-1:0] upper_i,
  output logic [VLEN-1:0]      result_o,
  output logic                 rf_we_o,
  output logic                 mem_we_o,
  output logic [ELEM-1:0]      mem_data_o,
  output logic                 illegal_o
);
  logic take, is_merge;
  logic [ELEM-1:0] low;

  assign take     = !ctl_i.use_mask || mask_bit_i;
  assign is_merge = (ctl_i.form == FORM_MERGE);
  assign low      = take ? src_low_i : (ctl_i.zero ? '0 : old_low_i);

  for (genvar e = 0; e < int'(NEL); e++) begin : g_el
    if (e == 0) begin : g_low
      assign result_o[ELEM-1:0] = low;
    end else if (e < int'(LEL)) begin : g_lane
      assign result_o[e*ELEM +: ELEM] = is_merge ? upper_i[(e-1)*ELEM +: ELEM] : '0;
    end else begin : g_hi
      assign result_o[e*ELEM +: ELEM] = '0;
    end
  end

  assign rf_we_o    = (ctl_i.form == FORM_LOAD) || is_merge;
  assign mem_we_o   = (ctl_i.form == FORM_STORE) && take;
  assign mem_data_o = src_low_i;
  assign illegal_o  = (ctl_i.form == FORM_BAD);
endmodule

// File: rtl/hmov_unit.sv
module hmov_unit
  import hmov_pkg::*;
#(
  parameter int unsigned VLEN  = 512,
  parameter int unsigned LANE  = 128,
  parameter int unsigned ELEM  = 16,
  parameter int unsigned NREG  = 32,
  parameter int unsigned NMASK = 8,
  parameter int unsigned MASKW = 8,
  localparam int unsigned RAW  = $clog2(NREG),
  localparam int unsigned MAW  = $clog2(NMASK)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [7:0]      opcode_i,
  input  logic            is_mem_i,
  input  logic [RAW-1:0]  reg_idx_i,
  input  logic [RAW-1:0]  rm_idx_i,
  input  logic [RAW-1:0]  src1_idx_i,
  input  logic [MAW-1:0]  mask_idx_i,
  input  logic            zero_i,
  input  logic [ELEM-1:0] mem_rdata_i,
  input  logic            fill_we_i,
  input  logic [RAW-1:0]  fill_idx_i,
  input  logic [VLEN-1:0] fill_data_i,
  input  logic            mfill_we_i,
  input  logic [MAW-1:0]  mfill_idx_i,
  input  logic [MASKW-1:0] mfill_data_i,
  output logic            done_o,
  output logic            illegal_o,
  output logic            rd_we_o,
  output logic [RAW-1:0]  rd_idx_o,
  output logic [VLEN-1:0] rd_data_o,
  output logic            mem_we_o,
  output logic [ELEM-1:0] mem_wdata_o
);
  localparam int unsigned NRD = 3;
  localparam int unsigned P_DST = 0;
  localparam int unsigned P_SRC = 1;
  localparam int unsigned P_UP  = 2;

  ctl_t            ctl;
  logic [RAW-1:0]  dst_idx, src_idx;
  logic [NRD-1:0][RAW-1:0]  vrf_ridx;
  logic [NRD-1:0][VLEN-1:0] vrf_rdata;
  logic [0:0][MAW-1:0]      mrf_ridx;
  logic [0:0][MASKW-1:0]    mrf_rdata;
  logic [ELEM-1:0] src_low;
  logic [VLEN-1:0] result;
  logic            rf_we_c, mem_we_c, illegal_c, commit;
  logic [ELEM-1:0] mem_data_c;
  logic            vrf_we;
  logic [RAW-1:0]  vrf_widx;
  logic [VLEN-1:0] vrf_wdata;

  hmov_decode #(.RAW(RAW), .MAW(MAW)) u_dec (
    .opcode_i   (opcode_i),
    .is_mem_i   (is_mem_i),
    .reg_idx_i  (reg_idx_i),
    .rm_idx_i   (rm_idx_i),
    .mask_idx_i (mask_idx_i),
    .zero_i     (zero_i),
    .ctl_o      (ctl),
    .dst_idx_o  (dst_idx),
    .src_idx_o  (src_idx)
  );

  assign vrf_ridx[P_DST] = dst_idx;
  assign vrf_ridx[P_SRC] = src_idx;
  assign vrf_ridx[P_UP]  = src1_idx_i;
  assign mrf_ridx[0]     = mask_idx_i;

  // move commit has priority over the setup port
  assign commit    = valid_i && rf_we_c;
  assign vrf_we    = commit || fill_we_i;
  assign vrf_widx  = commit ? dst_idx : fill_idx_i;
  assign vrf_wdata = commit ? result : fill_data_i;

  hmov_regfile #(.WIDTH(VLEN), .DEPTH(NREG), .NRD(NRD)) u_vrf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (vrf_we),
    .widx_i  (vrf_widx),
    .wdata_i (vrf_wdata),
    .ridx_i  (vrf_ridx),
    .rdata_o (vrf_rdata)
  );

  hmov_regfile #(.WIDTH(MASKW), .DEPTH(NMASK), .NRD(1)) u_mrf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mfill_we_i),
    .widx_i  (mfill_idx_i),
    .wdata_i (mfill_data_i),
    .ridx_i  (mrf_ridx),
    .rdata_o (mrf_rdata)
  );

  assign src_low = (ctl.form == FORM_LOAD) ? mem_rdata_i : vrf_rdata[P_SRC][ELEM-1:0];

  hmov_merge #(.VLEN(VLEN), .LANE(LANE), .ELEM(ELEM)) u_mrg (
    .ctl_i      (ctl),
    .mask_bit_i (mrf_rdata[0][0]),
    .src_low_i  (src_low),
    .old_low_i  (vrf_rdata[P_DST][ELEM-1:0]),
    .upper_i    (vrf_rdata[P_UP][LANE-1:ELEM]),
    .result_o   (result),
    .rf_we_o    (rf_we_c),
    .mem_we_o   (mem_we_c),
    .mem_data_o (mem_data_c),
    .illegal_o  (illegal_c)
  );

  logic unused_rd;
  assign unused_rd = &{1'b0, vrf_rdata[P_DST][VLEN-1:ELEM], vrf_rdata[P_SRC][VLEN-1:ELEM],
                       vrf_rdata[P_UP][VLEN-1:LANE], vrf_rdata[P_UP][ELEM-1:0],
                       mrf_rdata[0][MASKW-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      illegal_o   <= 1'b0;
      rd_we_o     <= 1'b0;
      rd_idx_o    <= '0;
      rd_data_o   <= '0;
      mem_we_o    <= 1'b0;
      mem_wdata_o <= '0;
    end else begin
      done_o    <= valid_i;
      illegal_o <= valid_i && illegal_c;
      rd_we_o   <= commit;
      mem_we_o  <= valid_i && mem_we_c;
      if (commit) begin
        rd_idx_o  <= dst_idx;
        rd_data_o <= result;
      end
      if (valid_i && mem_we_c) mem_wdata_o <= mem_data_c;
    end
  end

  p_done_follows_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  p_one_outcome_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rd_we_o, mem_we_o, illegal_o}) <= 1);
  p_no_outcome_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(rd_we_o || mem_we_o || illegal_o));
  p_store_no_reg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctl.form == FORM_STORE) |=> !rd_we_o);
  p_illegal_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !(rd_we_o || mem_we_o));
  p_load_upper_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctl.form == FORM_LOAD) |=> (rd_we_o && rd_data_o[VLEN-1:ELEM] == '0));
  p_merge_high_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctl.form == FORM_MERGE) |=> (rd_we_o && rd_data_o[VLEN-1:LANE] == '0));
  p_zero_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (ctl.form == FORM_LOAD || ctl.form == FORM_MERGE) && ctl.use_mask
     && !mrf_rdata[0][0] && zero_i) |=> rd_data_o[ELEM-1:0] == '0);
  p_store_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctl.form == FORM_STORE && ctl.use_mask && !mrf_rdata[0][0]) |=> !mem_we_o);
  p_bad_opcode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i != OPC_TO_REG && opcode_i != OPC_FROM_REG) |=> illegal_o);
endmodule

// File: tb/hmov_unit_tb.sv
module hmov_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic valid, is_mem, zero, fill_we, mfill_we;
  logic [7:0] opcode;
  logic [4:0] reg_idx, rm_idx, src1_idx, fill_idx;
  logic [2:0] mask_idx, mfill_idx;
  logic [15:0] mem_rdata;
  logic [511:0] fill_data;
  logic [7:0] mfill_data;
  logic done, illegal, rd_we, mem_we;
  logic [4:0] rd_idx;
  logic [511:0] rd_data;
  logic [15:0] mem_wdata;

  hmov_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .opcode_i(opcode), .is_mem_i(is_mem),
    .reg_idx_i(reg_idx), .rm_idx_i(rm_idx), .src1_idx_i(src1_idx), .mask_idx_i(mask_idx),
    .zero_i(zero), .mem_rdata_i(mem_rdata), .fill_we_i(fill_we), .fill_idx_i(fill_idx),
    .fill_data_i(fill_data), .mfill_we_i(mfill_we), .mfill_idx_i(mfill_idx),
    .mfill_data_i(mfill_data), .done_o(done), .illegal_o(illegal), .rd_we_o(rd_we),
    .rd_idx_o(rd_idx), .rd_data_o(rd_data), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [511:0] shadow [32];

  task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] pat(int idx);
    logic [511:0] v;
    for (int w = 0; w < 16; w++) v[w*32 +: 32] = 32'h9E37_0000 ^ (idx * 32'h0101_0307) ^ (w * 32'h0011_2233);
    return v;
  endfunction

  task automatic fill(int idx, logic [511:0] d);
    @(negedge clk);
    fill_we = 1; fill_idx = 5'(idx); fill_data = d;
    @(negedge clk);
    fill_we = 0;
    shadow[idx] = d;
  endtask

  task automatic mfill(int idx, logic [7:0] d);
    @(negedge clk);
    mfill_we = 1; mfill_idx = 3'(idx); mfill_data = d;
    @(negedge clk);
    mfill_we = 0;
  endtask

  task automatic drive(logic [7:0] op, logic mem, int r, int m, int s1, int k, logic z, logic [15:0] md);
    valid = 1; opcode = op; is_mem = mem; reg_idx = 5'(r); rm_idx = 5'(m);
    src1_idx = 5'(s1); mask_idx = 3'(k); zero = z; mem_rdata = md;
  endtask

  task automatic issue(logic [7:0] op, logic mem, int r, int m, int s1, int k, logic z, logic [15:0] md);
    @(negedge clk);
    drive(op, mem, r, m, s1, k, z, md);
    @(negedge clk);
    valid = 0;
  endtask

  function automatic logic [511:0] merged(int s1, logic [15:0] low);
    return {384'b0, shadow[s1][127:16], low};
  endfunction

  // masks: 1 -> bit0 set, 2 -> bit0 clear
  task automatic t_load;
    issue(8'h10, 1, 3, 0, 0, 0, 0, 16'h3C00);
    chk("R1 load we", rd_we, 1); chk("R1 load idx", rd_idx, 3);
    chk("R1 load data", rd_data, {496'b0, 16'h3C00});
    chk("R10 done", done, 1); chk("R2 no mem we on load", mem_we, 0);
    shadow[3] = rd_data;
    @(negedge clk); chk("R10 done single", done, 0);
    issue(8'h10, 1, 4, 0, 0, 1, 0, 16'hABCD);
    chk("R4 mask bit set load", rd_data, {496'b0, 16'hABCD});
  endtask

  task automatic t_load_masked;
    fill(6, pat(6));
    issue(8'h10, 1, 6, 0, 0, 2, 1, 16'h1111);
    chk("R5 load zeroed", rd_data, '0); chk("R5 load we", rd_we, 1);
    fill(6, pat(6));
    issue(8'h10, 1, 6, 0, 0, 2, 0, 16'h1111);
    chk("R6 load keep", rd_data, {496'b0, pat(6)[15:0]});
  endtask

  task automatic t_store;
    fill(5, pat(5));
    issue(8'h11, 1, 5, 0, 0, 1, 0, 16'h0);
    chk("R2 store we", mem_we, 1); chk("R2 store data", mem_wdata, pat(5)[15:0]);
    chk("R2 store no reg", rd_we, 0); chk("R2 illegal", illegal, 0);
    issue(8'h11, 1, 5, 0, 0, 2, 0, 16'h0);
    chk("R7 masked store mem", mem_we, 0); chk("R7 masked store reg", rd_we, 0);
    chk("R7 masked store done", done, 1);
    issue(8'h11, 1, 5, 0, 0, 1, 1, 16'h0);
    chk("R8 zero store illegal", illegal, 1); chk("R8 no mem", mem_we, 0);
    chk("R8 no reg", rd_we, 0);
  endtask

  task automatic t_bad;
    issue(8'h12, 1, 3, 0, 0, 0, 0, 16'h5555);
    chk("R9 illegal", illegal, 1); chk("R9 no reg", rd_we, 0); chk("R9 no mem", mem_we, 0);
    issue(8'h00, 0, 3, 1, 2, 0, 0, 16'h5555);
    chk("R9 illegal reg form", illegal, 1);
  endtask

  task automatic t_merge;
    fill(1, pat(1)); fill(2, pat(2)); fill(9, pat(9)); fill(7, pat(7));
    issue(8'h10, 0, 7, 1, 2, 0, 0, 16'h0);
    chk("R3 op10 idx", rd_idx, 7);
    chk("R3 op10 data", rd_data, merged(2, pat(1)[15:0]));
    issue(8'h11, 0, 1, 8, 2, 0, 0, 16'h0);
    chk("R3 op11 idx", rd_idx, 8);
    chk("R3 op11 data", rd_data, merged(2, pat(1)[15:0]));
    issue(8'h10, 0, 9, 1, 2, 2, 0, 16'h0);
    chk("R6 merge keep", rd_data, merged(2, pat(9)[15:0]));
    issue(8'h10, 0, 9, 1, 2, 2, 1, 16'h0);
    chk("R5 merge zero", rd_data, merged(2, 16'h0));
  endtask

  task automatic t_mask0;
    mfill(0, 8'hFE);
    issue(8'h10, 1, 12, 0, 0, 0, 1, 16'h4242);
    chk("R4 mask0 unmasked", rd_data, {496'b0, 16'h4242});
  endtask

  task automatic t_special;
    issue(8'h10, 1, 13, 0, 0, 0, 0, 16'h7E01);
    chk("R11 nan load", rd_data[15:0], 16'h7E01);
    issue(8'h10, 1, 14, 0, 0, 0, 0, 16'h0001);
    chk("R11 denormal load", rd_data[15:0], 16'h0001);
    fill(15, {496'b0, 16'hFC00});
    issue(8'h11, 1, 15, 0, 0, 0, 0, 16'h0);
    chk("R11 neg inf store", mem_wdata, 16'hFC00);
  endtask

  task automatic t_b2b;
    @(negedge clk);
    drive(8'h10, 1, 10, 0, 0, 0, 0, 16'h1234);
    @(negedge clk);
    chk("R12 first load", rd_data, {496'b0, 16'h1234});
    drive(8'h11, 1, 10, 0, 0, 0, 0, 16'h0);
    @(negedge clk);
    valid = 0;
    chk("R12 store sees write", mem_wdata, 16'h1234);
    chk("R12 store we", mem_we, 1);
    chk("R10 done held", done, 1);
  endtask

  initial begin
    valid = 0; opcode = 0; is_mem = 0; zero = 0; reg_idx = 0; rm_idx = 0; src1_idx = 0;
    mask_idx = 0; mem_rdata = 0; fill_we = 0; fill_idx = 0; fill_data = 0;
    mfill_we = 0; mfill_idx = 0; mfill_data = 0;
    for (int i = 0; i < 32; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset done", done, 0); chk("R10 reset rd_we", rd_we, 0);
    chk("R10 reset mem_we", mem_we, 0); chk("R10 reset illegal", illegal, 0);
    mfill(1, 8'h01); mfill(2, 8'hFE);
    t_load(); t_load_masked(); t_store(); t_bad(); t_merge(); t_mask0(); t_special(); t_b2b();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule